// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Processor

This block is a small single-accumulator processor. It repeats a fetch-then-execute cycle against a word-addressed memory. The memory port is synchronous and single-ported: the block drives an address, write data and a write enable, and read data comes back on the clock edge after the address was presented. The block holds three registers: a program counter, an instruction register and an accumulator. Each instruction is one memory word. It carries a 4-bit operation field and a 12-bit direct operand address.

Arithmetic uses sign-magnitude words, not two's complement. To add, the block compares the two magnitudes, subtracts the smaller from the larger when the signs differ, and takes the sign of the larger. Each instruction takes four clock cycles, in this order: fetch, decode, execute, write-back. A halt instruction freezes the machine and raises a status output. The processor uses the memory to hold both its program and its data.

Top module: `acc_cpu`

## Requirements
- R1: While synchronous reset is high, the program counter, instruction register and accumulator are cleared, `halted`, `overflow` and `mem_we` are 0, and `mem_addr` is 0, so the first fetch reads word 0.
- R2: An instruction word splits into an operation field in bits 15:12 and an operand address in bits 11:0. Instructions are fetched from consecutive addresses, and every non-halt instruction takes exactly four clock cycles.
- R3: Operation 4'h1 copies the addressed memory word into the accumulator.
- R4: Operation 4'h2 writes the accumulator to the addressed word, with `mem_we` high for exactly one cycle.
- R5: Operation 4'h5 adds the addressed word to the accumulator. A data word has its sign in bit 15 (1 = negative) and its magnitude in bits 14:0. When the signs match, the magnitudes are summed and the sign is kept.
- R6: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the operand with the larger magnitude.
- R7: A zero sum is always written with sign bit 0. The add never produces 16'h8000.
- R8: When a magnitude sum exceeds 15 bits, only the low 15 bits are kept and `overflow` is set. `overflow` stays set until reset.
- R9: Operation 4'hF raises `halted`, which stays high until reset. Once halted, the block issues no further memory writes and `mem_addr` stays constant.
- R10: Every operation value other than 1, 2, 5 and F is a no-op. It leaves the accumulator unchanged, writes nothing, and still takes four cycles.
- R11: The program counter wraps from 12'hFFF to 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| overflow | output | 1 | Sticky flag for magnitude overflow in an add |

## Verification
The hardest state to reach from the ports is the program counter wrapping past the top of the address space. To get there, the bench fills the whole memory with no-op words. It places an add at the last address and a store just after address zero. The store writes a different value on its second pass, and that value can only be correct if the last word executed and control then returned to word zero. The cycle gap between the two stores confirms the count. The accumulator is never visible directly, so every arithmetic corner case is followed by a store. The zero-sum and overflow operand pairs are chosen so that each stored word tells the sign rule and the magnitude rule apart.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_WBACK  = 3'd3,
    PH_HALT   = 3'd4
  } phase_t;
endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] fetched_opc,
  output phase_t           phase
);
  phase_t phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_FETCH:  phase_nx = PH_DECODE;
      PH_DECODE: phase_nx = (fetched_opc == OPC_HALT) ? PH_HALT : PH_EXEC;
      PH_EXEC:   phase_nx = PH_WBACK;
      PH_WBACK:  phase_nx = PH_FETCH;
      PH_HALT:   phase_nx = PH_HALT;
      default:   phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_nx;
  end

  // R9: once halted, the sequencer never leaves the halt phase
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    phase == PH_HALT |=> phase == PH_HALT);

  // R2: a fetch is always followed by a decode
  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> phase == PH_DECODE);
endmodule

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] sum,
  output logic              mag_carry
);
  localparam int MAG_W = DATA_W - 1;

  logic             sgn_a, sgn_b, sgn_r;
  logic [MAG_W-1:0] mag_a, mag_b, mag_r;
  logic [MAG_W:0]   wide;

  always_comb begin
    sgn_a     = op_a[DATA_W-1];
    sgn_b     = op_b[DATA_W-1];
    mag_a     = op_a[MAG_W-1:0];
    mag_b     = op_b[MAG_W-1:0];
    wide      = '0;
    mag_carry = 1'b0;
    if (sgn_a == sgn_b) begin
      wide      = {1'b0, mag_a} + {1'b0, mag_b};
      mag_r     = wide[MAG_W-1:0];
      mag_carry = wide[MAG_W];
      sgn_r     = sgn_a;
    end else if (mag_a >= mag_b) begin
      mag_r = mag_a - mag_b;
      sgn_r = sgn_a;
    end else begin
      mag_r = mag_b - mag_a;
      sgn_r = sgn_b;
    end
    if (mag_r == '0) sgn_r = 1'b0;
    sum = {sgn_r, mag_r};
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic              overflow
);
  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [OPC_W-1:0]  fetched_opc;
  logic [OPC_W-1:0]  ir_opc;
  logic [DATA_W-1:0] add_sum;
  logic              add_carry;
  phase_t            phase;

  assign fetched_opc = mem_rdata[DATA_W-1:OPC_LSB];
  assign ir_opc      = ir_q[DATA_W-1:OPC_LSB];

  acc_cpu_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .fetched_opc (fetched_opc),
    .phase       (phase)
  );

  acc_cpu_smadd #(.DATA_W(DATA_W)) u_add (
    .op_a      (acc_q),
    .op_b      (mem_rdata),
    .sum       (add_sum),
    .mag_carry (add_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      ir_q      <= '0;
      acc_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      halted    <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      case (phase)
        PH_DECODE: begin
          ir_q <= mem_rdata;
          if (fetched_opc == OPC_HALT) begin
            halted <= 1'b1;
          end else begin
            pc_q     <= pc_q + 1'b1;
            mem_addr <= mem_rdata[ADDR_W-1:0];
            if (fetched_opc == OPC_STORE) begin
              mem_we    <= 1'b1;
              mem_wdata <= acc_q;
            end
          end
        end
        PH_EXEC: mem_we <= 1'b0;
        PH_WBACK: begin
          if (ir_opc == OPC_LOAD) acc_q <= mem_rdata;
          if (ir_opc == OPC_ADD) begin
            acc_q    <= add_sum;
            overflow <= overflow | add_carry;
          end
          mem_addr <= pc_q;
        end
        default: ;
      endcase
    end
  end

  // R4: a write is a single-cycle pulse
  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4: a write targets the operand of a store instruction
  assert_store_target_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ir_opc == OPC_STORE && mem_addr == ir_q[ADDR_W-1:0]));

  // R11: decode advances the program counter by one, modulo the address space
  assert_pc_step_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && fetched_opc != OPC_HALT) |=>
      pc_q == $past(pc_q) + {{(ADDR_W-1){1'b0}}, 1'b1});

  // R7: an add never leaves negative zero in the accumulator
  assert_no_neg_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WBACK && ir_opc == OPC_ADD) |=>
      acc_q != {1'b1, {(DATA_W-1){1'b0}}});

  // R8: the overflow flag is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9: a halted machine is quiet on the memory port
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && $stable(mem_addr)));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;
  logic          overflow;

  always #5 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .overflow(overflow)
  );

  logic [DW-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          o;
    int            gap;
    string         req;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_we = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic o, input int gap, input string req);
    item_t it;
    it.a = a; it.d = d; it.o = o; it.gap = gap; it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compare every write pulse with the scoreboard head
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9/R10 unexpected write", {20'd0, mem_addr}, 32'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(mem_addr == it.a, it.req, {20'd0, mem_addr}, {20'd0, it.a});
        check(mem_wdata == it.d, it.req, {16'd0, mem_wdata}, {16'd0, it.d});
        check(overflow == it.o, {it.req, " R8 flag"}, {31'd0, overflow}, {31'd0, it.o});
        if (it.gap != 0)
          check(cyc - last_we == it.gap, {it.req, " R2 timing"}, cyc - last_we, it.gap);
      end
      last_we = cyc;
    end
  end

  task automatic clear_mem(input logic [DW-1:0] fill);
    for (int i = 0; i < DEPTH; i++) mem[i] = fill;
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  initial begin
    logic [AW-1:0] held;
    // ---------- program A ----------
    clear_mem('0);
    mem[12'h100] = 16'h0005; mem[12'h101] = 16'h0007; mem[12'h102] = 16'h8014;
    mem[12'h103] = 16'h0008; mem[12'h104] = 16'h8003; mem[12'h105] = 16'h8004;
    mem[12'h106] = 16'h0003; mem[12'h107] = 16'h7FFF; mem[12'h108] = 16'h0002;
    mem[0]  = ins(4'h1, 12'h100);
    mem[1]  = ins(4'h5, 12'h101);
    mem[2]  = ins(4'h2, 12'h200);
    mem[3]  = ins(4'h5, 12'h102);
    mem[4]  = ins(4'h2, 12'h201);
    mem[5]  = ins(4'h5, 12'h103);
    mem[6]  = ins(4'h2, 12'h202);
    mem[7]  = ins(4'h1, 12'h104);
    mem[8]  = ins(4'h5, 12'h105);
    mem[9]  = ins(4'h2, 12'h203);
    mem[10] = ins(4'h5, 12'h106);
    mem[11] = ins(4'h2, 12'h204);
    mem[12] = ins(4'h3, 12'h100);
    mem[13] = ins(4'h6, 12'h107);
    mem[14] = ins(4'h2, 12'h205);
    mem[15] = ins(4'h1, 12'h107);
    mem[16] = ins(4'h5, 12'h108);
    mem[17] = ins(4'h2, 12'h206);
    mem[18] = ins(4'h1, 12'h100);
    mem[19] = ins(4'h2, 12'h207);
    mem[20] = 16'hF000;
    mem[21] = ins(4'h2, 12'h208);

    expect_store(12'h200, 16'h000C, 1'b0, 0,  "R3/R5 same-sign add");
    expect_store(12'h201, 16'h8008, 1'b0, 8,  "R6 larger negative wins");
    expect_store(12'h202, 16'h0000, 1'b0, 8,  "R7 zero sum positive");
    expect_store(12'h203, 16'h8007, 1'b0, 12, "R5 negative plus negative");
    expect_store(12'h204, 16'h8004, 1'b0, 8,  "R6 negative minus smaller");
    expect_store(12'h205, 16'h8004, 1'b0, 12, "R10 undefined ops no-op");
    expect_store(12'h206, 16'h0001, 1'b1, 12, "R8 overflow wraps magnitude");
    expect_store(12'h207, 16'h0005, 1'b1, 8,  "R4/R8 store after overflow");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_addr == '0, "R1 mem_addr", {20'd0, mem_addr}, 0);
    check(mem_we == 1'b0, "R1 mem_we", {31'd0, mem_we}, 0);
    check(halted == 1'b0, "R1 halted", {31'd0, halted}, 0);
    check(overflow == 1'b0, "R1 overflow", {31'd0, overflow}, 0);
    rst = 1'b0;

    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    check(halted == 1'b1, "R9 halted raised", {31'd0, halted}, 1);
    check(sb_q.size() == 0, "R3 all stores seen", sb_q.size(), 0);
    check(overflow == 1'b1, "R8 overflow held", {31'd0, overflow}, 1);
    held = mem_addr;
    repeat (40) @(negedge clk);
    check(mem_addr == held, "R9 address frozen", {20'd0, mem_addr}, {20'd0, held});
    check(halted == 1'b1, "R9 halted sticky", {31'd0, halted}, 1);
    check(mem[12'h208] == 16'h0000, "R9 no store after halt", {16'd0, mem[12'h208]}, 0);

    // ---------- wrap program ----------
    rst = 1'b1;
    @(negedge clk);
    clear_mem('0);
    mem[12'h300] = 16'h0001;
    mem[0]       = ins(4'h5, 12'h300);
    mem[1]       = ins(4'h2, 12'h301);
    mem[12'hFFF] = ins(4'h5, 12'h300);
    expect_store(12'h301, 16'h0001, 1'b0, 0,     "R11 first pass");
    expect_store(12'h301, 16'h0003, 1'b0, 16384, "R11 after wrap");
    repeat (2) @(negedge clk);
    check(halted == 1'b0, "R1 halted cleared", {31'd0, halted}, 0);
    check(overflow == 1'b0, "R1 overflow cleared", {31'd0, overflow}, 0);
    rst = 1'b0;
    for (int i = 0; i < 20000 && sb_q.size() != 0; i++) @(negedge clk);
    check(sb_q.size() == 0, "R11 wrap stores seen", sb_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule